// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block counts activity on one external input pin into a 16-bit accumulator. It has two modes. In event mode it adds one for each falling edge or for each rising edge of the pin, as software selects. In gated mode it adds one for each divide-by-64 tick of the bus clock while the pin sits at the chosen active level. The tick comes from a prescaler that runs only while the main timer enable is set.

Two sticky flags record activity. The edge flag marks the selected edge in event mode, or the trailing edge of the gate in gated mode. The overflow flag marks a wrap of the count to zero. Each flag has an interrupt enable. Software reaches the block through a byte-wide register port with four registers: control, flags, count high byte and count low byte. A one-cycle pulse is sent out each time the count advances, so the main timer can use the accumulator as its clock source.

Register layout, selected by `bus_addr`: 0 = control, 1 = flags, 2 = count high byte, 3 = count low byte. The control bits are: bit 0 accumulator enable, bit 1 gated mode, bit 2 edge select, bit 3 edge interrupt enable, bit 4 overflow interrupt enable. Bits 7..5 read as zero. In the flags register, bit 0 is the edge flag and bit 1 is the overflow flag.

Top module: `edge_gate_accum`

## Requirements
- R1: After reset the control register, the flags register, both count bytes, `irq_edge`, `irq_ovf` and `acc_tick` are all zero.
- R2: In event mode (control bit 1 = 0), edge select 0 counts falling edges and edge select 1 counts rising edges, one per edge. The pin passes through a two-flop synchronizer, so a pin change driven before rising clock edge N changes the count at edge N+2.
- R3: In gated mode (control bit 1 = 1), the count adds one per divide-by-64 tick while the synchronized pin is high (edge select 0) or low (edge select 1). The first tick completes on the 64th rising edge after the timer enable is set. While `tmr_en` is low, no tick is made and gated mode does not count.
- R4: The edge flag sets on the falling edge for edge select 0 and on the rising edge for edge select 1, in both modes. In gated mode this is the trailing edge of the gate. The opposite edge never sets it.
- R5: While the accumulator enable (control bit 0) is clear, the count does not change from pin activity and the edge flag does not set.
- R6: Event counting works with `tmr_en` low.
- R7: An increment from 0xFFFF wraps the count to 0x0000 and sets the overflow flag.
- R8: Writing the flags register clears each flag whose bit is written 1 (bit 0 edge, bit 1 overflow). Bits written 0 leave their flag unchanged.
- R9: While `fast_clr_en` is high, any read or write of address 2 or 3 clears both flags. While it is low, such accesses leave the flags alone.
- R10: A write to address 2 replaces the count's high byte and a write to address 3 replaces its low byte. The other byte keeps its value, and reads return the current bytes.
- R11: `irq_edge` is high exactly when the edge flag and control bit 3 are both set. `irq_ovf` is high exactly when the overflow flag and control bit 4 are both set.
- R12: `acc_tick` pulses high for one cycle in each cycle whose clock edge advances the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| tmr_en | input | 1 | Main timer enable; runs the divide-by-64 prescaler |
| fast_clr_en | input | 1 | Lets count-byte accesses clear the flags |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_edge | output | 1 | Edge interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| acc_tick | output | 1 | One-cycle pulse per count increment, for the main timer |

## Verification
The bench targets three kinds of bugs.

**Polarity and timing.** It counts edges with each polarity selected and times the synchronizer to the exact cycle. A swapped edge select or a missing synchronizer stage shows up as a wrong count or an early change. In gated mode it starts the timer from a known phase and checks the number of ticks. It also checks that nothing counts with the timer off or the gate closed, and that the flag waits for the trailing edge. A design that flags the leading edge, or gates on the wrong level, fails these checks.

**Overflow and flag clearing.** It drives the count through 0xFFFF and checks the wrap. It then exercises each clear path: the selective write-one clear, where a design that clears both flags fails, and the fast clear through a count access, where a design that ignores `fast_clr_en` fails.

**Disabled accumulator.** It checks that a disabled accumulator neither counts nor sets the edge flag.

// File: rtl/eg_accum_pkg.sv
// Shared register decode and control layout for the dual-mode pulse accumulator.
package eg_accum_pkg;
    localparam int BYTE_W   = 8;
    localparam int CTRL_W   = 5;
    localparam int FLAG_EDG = 0;
    localparam int FLAG_OVF = 1;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_FLAG   = 2'd1,
        REG_CNT_HI = 2'd2,
        REG_CNT_LO = 2'd3
    } reg_sel_e;

    // Control register, bit 0 at the bottom.
    typedef struct packed {
        logic ovf_ie;
        logic edge_ie;
        logic edge_sel;
        logic gated;
        logic enable;
    } ctrl_t;
endpackage

// File: rtl/eg_pin_sync.sv
// Synchronizes the asynchronous pin through STAGES flops and reports its
// settled level plus one-cycle rise and fall pulses. Assumes STAGES >= 2 and
// that the pin idles low out of reset.
module eg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the synchronizer chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/eg_tick_div.sv
// Divides the bus clock by RATIO while run is high; tick is high for one cycle
// per period. Clearing run parks the divider at zero, so the first tick after
// run rises completes on the RATIO-th clock edge.
module eg_tick_div #(
    parameter int RATIO = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [W-1:0] LAST = W'(RATIO - 1);

    logic [W-1:0] cnt;

    // Count bus clocks while the timer runs, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/eg_count_core.sv
// Holds the accumulator count. Software byte writes take priority over an
// increment in the same cycle. wrap flags an increment from all-ones.
module eg_count_core #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [2*BYTE_W-1:0] count,
    output logic                wrap
);
    localparam int CNT_W = 2 * BYTE_W;

    // Apply byte writes, otherwise advance on an increment request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_hi || wr_lo) begin
            if (wr_hi) count[CNT_W-1:BYTE_W] <= wdata;
            if (wr_lo) count[BYTE_W-1:0]     <= wdata;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign wrap = inc && !wr_hi && !wr_lo && (count == {CNT_W{1'b1}});
endmodule

// File: rtl/edge_gate_accum.sv
// Dual-mode pulse accumulator top. Counts selected pin edges or gated
// divide-by-64 ticks into a 16-bit count, keeps edge and overflow flags, and
// exposes a byte-wide register port. Assumes a single clock domain for the bus
// and a synchronous active-low reset; the pin may be asynchronous.
module edge_gate_accum
    import eg_accum_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int GATE_DIV    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              tmr_en,
    input  logic              fast_clr_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq_edge,
    output logic              irq_ovf,
    output logic              acc_tick
);
    localparam int CNT_W = 2 * BYTE_W;

    ctrl_t            ctrl;
    logic             pin_lvl, pin_rise, pin_fall;
    logic             gate_tick;
    logic             edge_hit, ev_inc, gt_inc, inc;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             edge_flag, ovf_flag;
    logic             wr_ctrl, wr_flag, wr_hi, wr_lo, fast_hit;

    eg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_in),
        .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
    );

    eg_tick_div #(.RATIO(GATE_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(tmr_en), .tick(gate_tick)
    );

    // Register decode for writes and for fast-clear accesses.
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
        wr_flag  = bus_wr && (bus_addr == REG_FLAG);
        wr_hi    = bus_wr && (bus_addr == REG_CNT_HI);
        wr_lo    = bus_wr && (bus_addr == REG_CNT_LO);
        fast_hit = fast_clr_en && (bus_wr || bus_rd) &&
                   ((bus_addr == REG_CNT_HI) || (bus_addr == REG_CNT_LO));
    end

    // Pick the qualifying edge and the increment source for the active mode.
    always_comb begin
        edge_hit = ctrl.edge_sel ? pin_rise : pin_fall;
        ev_inc   = ctrl.enable && !ctrl.gated && edge_hit;
        gt_inc   = ctrl.enable && ctrl.gated && gate_tick &&
                   (pin_lvl != ctrl.edge_sel);
        inc      = ev_inc || gt_inc;
    end

    eg_count_core #(.BYTE_W(BYTE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .inc(inc),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(bus_wdata),
        .count(count), .wrap(wrap)
    );

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_flag <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            edge_flag <= (ctrl.enable && edge_hit) ||
                         (edge_flag && !(wr_flag && bus_wdata[FLAG_EDG]) && !fast_hit);
            ovf_flag  <= wrap ||
                         (ovf_flag && !(wr_flag && bus_wdata[FLAG_OVF]) && !fast_hit);
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl;
            REG_FLAG: begin
                bus_rdata[FLAG_EDG] = edge_flag;
                bus_rdata[FLAG_OVF] = ovf_flag;
            end
            REG_CNT_HI: bus_rdata = count[CNT_W-1:BYTE_W];
            REG_CNT_LO: bus_rdata = count[BYTE_W-1:0];
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_edge = edge_flag && ctrl.edge_ie;
    assign irq_ovf  = ovf_flag && ctrl.ovf_ie;
    assign acc_tick = inc;
endmodule

// File: rtl/eg_accum_checker.sv
// Temporal checks on the pulse accumulator, bound to every edge_gate_accum.
module eg_accum_checker #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [1:0]          bus_addr,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic                tmr_en,
    input logic                acc_tick,
    input logic                irq_edge,
    input logic                irq_ovf,
    input logic [2*BYTE_W-1:0] count,
    input logic                ovf_flag,
    input logic [4:0]          ctrl
);
    localparam int CNT_W = 2 * BYTE_W;
    logic cnt_wr;
    assign cnt_wr = bus_wr && bus_addr[1];

    // R12: every tick advances the count by one.
    a_r12_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
        acc_tick && !cnt_wr |=> count == CNT_W'($past(count) + 1'b1));

    // R5: a disabled accumulator leaves the count alone.
    a_r5_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] && !cnt_wr |=> $stable(count));

    // R3: gated mode without the timer does not count.
    a_r3_no_timer_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[1] && !tmr_en && !cnt_wr |=> $stable(count));

    // R7: a wrap to zero raises the overflow flag.
    a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        acc_tick && !cnt_wr && (count == {CNT_W{1'b1}}) |=> ovf_flag);

    // R8: a write-one clear of overflow takes effect without a new wrap.
    a_r8_ovf_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == 2'd1) && bus_wdata[1] && !acc_tick |=> !ovf_flag);

    // R10: a high-byte write lands in the count.
    a_r10_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == 2'd2) |=> count[CNT_W-1:BYTE_W] == $past(bus_wdata));

    // R11: interrupts never rise without their enable.
    a_r11_edge_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_edge) |-> ctrl[3]);
    a_r11_ovf_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ovf) |-> ctrl[4]);
endmodule

bind edge_gate_accum eg_accum_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tmr_en(tmr_en), .acc_tick(acc_tick),
    .irq_edge(irq_edge), .irq_ovf(irq_ovf), .count(count),
    .ovf_flag(ovf_flag), .ctrl(ctrl)
);

// File: tb/edge_gate_accum_tb.sv
// Vector table of pulse scenarios, then directed tests for timing and corners.
module edge_gate_accum_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0;
    logic       tmr_en = 1'b0;
    logic       fast_clr_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_edge, irq_ovf, acc_tick;

    int errors = 0;
    int checks = 0;
    int tick_seen = 0;

    edge_gate_accum u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tmr_en(tmr_en),
        .fast_clr_en(fast_clr_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_edge(irq_edge), .irq_ovf(irq_ovf), .acc_tick(acc_tick)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (acc_tick) tick_seen <= tick_seen + 1;

    typedef struct packed {
        logic [7:0] ctrl;
        logic       tmr;
        logic [7:0] pulses;
        logic [7:0] exp_cnt;
        logic       exp_flag;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'h01, 1'b0, 8'd3, 8'd3, 1'b1},  // R2 R6 falling edges, timer off
        '{8'h05, 1'b0, 8'd5, 8'd5, 1'b1},  // R2 rising edges
        '{8'h04, 1'b1, 8'd4, 8'd0, 1'b0},  // R5 disabled
        '{8'h03, 1'b0, 8'd2, 8'd0, 1'b1},  // R3 gated high, no timer
        '{8'h07, 1'b0, 8'd1, 8'd0, 1'b1}   // R3 gated low, no timer
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_strobe(input logic [1:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse();
        @(negedge clk); pin_in = 1'b1;
        repeat (4) @(negedge clk);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_count(output int c);
        logic [7:0] h, l;
        peek(2'd2, h);
        peek(2'd3, l);
        c = {h, l};
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int c, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(2'd0, d); check("R1 ctrl", d, 0);
        peek(2'd1, d); check("R1 flags", d, 0);
        read_count(c); check("R1 count", c, 0);
        check("R1 irqs and tick", {irq_edge, irq_ovf, acc_tick}, 0);

        // Vector table
        foreach (VEC[i]) begin
            tmr_en = VEC[i].tmr;
            wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'h03);
            base = tick_seen;
            wr(2'd0, VEC[i].ctrl);
            for (int p = 0; p < VEC[i].pulses; p++) pulse();
            read_count(c);
            check($sformatf("R2/R3/R5 vec%0d count", i), c, VEC[i].exp_cnt);
            peek(2'd1, d);
            check($sformatf("R4/R5 vec%0d edge flag", i), d[0], VEC[i].exp_flag);
            check($sformatf("R12 vec%0d tick pulses", i), tick_seen - base, VEC[i].exp_cnt);
        end
        tmr_en = 1'b0;

        // R2 synchronizer latency: change at edge N+2
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
        wr(2'd0, 8'h05);
        @(negedge clk); bus_addr = 2'd3; pin_in = 1'b1;
        @(negedge clk); check("R2 latency after 1 edge", bus_rdata, 0);
        @(negedge clk); check("R2 latency after 2 edges", bus_rdata, 0);
        @(negedge clk); check("R2 latency after 3 edges", bus_rdata, 1);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);

        // R3/R4 gated high with timer
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'h03);
        @(negedge clk); pin_in = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h03);
        @(negedge clk); tmr_en = 1'b1;
        repeat (64 * 3 + 10) @(negedge clk);
        bus_addr = 2'd3; #1;
        check("R3 gated high three ticks", bus_rdata, 3);
        bus_addr = 2'd1; #1;
        check("R4 no flag before trailing edge", bus_rdata[0], 0);
        @(negedge clk); pin_in = 1'b0;
        repeat (4) @(negedge clk);
        bus_addr = 2'd1; #1;
        check("R4 trailing falling edge flag", bus_rdata[0], 1);
        repeat (128) @(negedge clk);
        bus_addr = 2'd3; #1;
        check("R3 gate closed holds count", bus_rdata, 3);
        tmr_en = 1'b0;

        // R3/R4 gated low with timer
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'h03);
        wr(2'd0, 8'h07);
        @(negedge clk); tmr_en = 1'b1;
        repeat (64 * 2 + 10) @(negedge clk);
        bus_addr = 2'd3; #1;
        check("R3 gated low two ticks", bus_rdata, 2);
        @(negedge clk); pin_in = 1'b1;
        repeat (4) @(negedge clk);
        bus_addr = 2'd1; #1;
        check("R4 trailing rising edge flag", bus_rdata[0], 1);
        tmr_en = 1'b0;
        @(negedge clk); pin_in = 1'b0;
        repeat (4) @(negedge clk);

        // R7/R11 overflow with interrupts enabled
        wr(2'd0, 8'h19); wr(2'd1, 8'h03);
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        pulse();
        read_count(c); check("R7 wrap to zero", c, 0);
        peek(2'd1, d); check("R7 both flags set", d, 8'h03);
        check("R11 irq_ovf enabled", irq_ovf, 1);
        check("R11 irq_edge enabled", irq_edge, 1);
        wr(2'd0, 8'h01);
        check("R11 irqs masked", {irq_edge, irq_ovf}, 0);

        // R8 selective write-one clear
        wr(2'd1, 8'h02);
        peek(2'd1, d); check("R8 clear ovf only", d, 8'h01);
        wr(2'd1, 8'h00);
        peek(2'd1, d); check("R8 zero write no effect", d, 8'h01);
        wr(2'd1, 8'h01);
        peek(2'd1, d); check("R8 clear edge", d, 8'h00);

        // R9 fast clear
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        pulse();
        fast_clr_en = 1'b0;
        rd_strobe(2'd2);
        peek(2'd1, d); check("R9 no fast clear when off", d, 8'h03);
        fast_clr_en = 1'b1;
        rd_strobe(2'd3);
        peek(2'd1, d); check("R9 fast clear on count read", d, 8'h00);
        fast_clr_en = 1'b0;

        // R10 byte access
        wr(2'd2, 8'hA5); wr(2'd3, 8'h3C);
        read_count(c); check("R10 both bytes", c, 16'hA53C);
        wr(2'd2, 8'h12);
        read_count(c); check("R10 high byte only", c, 16'h123C);

        finish_run();
    end
endmodule